// File: doc/BRIEF.md
# Prescaled Timer/Counter with Edge Counting

This block is a 32-bit timer/counter that sits behind a simple word-addressed register port. It has two count sources. In timer mode a prescale counter steps on every clock, and the main count advances once each time the prescale counter reaches a programmable limit. In counter mode the main count advances on rising, falling or both edges of one of two external capture inputs. Both inputs are synchronized before their edges are detected.

Four match channels compare the running count against programmable values. Two capture channels record the count when a chosen edge arrives on their input. Each of these six sources sets a flag in a shared flag register. Software clears a flag by writing a one to it. If a new event and a clear land in the same clock, the event wins, so no event is lost. A control register enables counting and can hold both counters at zero. Out of reset it holds them at zero with counting disabled.

Top module: `ptc_top`

## Requirements
- R1: The control register is at offset 0x0. Bit 1 is the counter clear: while it is 1, the main count and the prescale count are held at zero. Bit 0 is the run enable. After rst_n the control register reads 0x2.
- R2: While both control bits are 0, the main count and the prescale count keep their values.
- R3: Timer mode is mode bits [1:0] = 00. The prescale count steps on every clock. On the clock in which it equals (or exceeds) the prescale value P, it returns to zero and the main count steps by one. Starting from zero, after n running clocks the main count is floor(n/(P+1)) and the prescale count is n mod (P+1).
- R4: In counter mode the main count steps on each rising edge (mode bits [1:0] = 01), each falling edge (10) or each edge of either kind (11) of the selected input. The prescale count does not move.
- R5: Mode bits [3:2] = 00 select capture input 0 and 01 select capture input 1. In counter mode the input that is not selected has no effect on the main count.
- R6: Each capture input passes through a two-flop synchronizer. A level change driven before clock edge k is counted at edge k+2, and not at edge k+1.
- R7: Flag register layout: bits 3..0 are match channels 3..0, bit 4 is capture channel 0, bit 5 is capture channel 1. Bits 31..6 read as zero.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R9: If a flag's set event and a write-one clear occur in the same clock, the flag ends up set.
- R10: Match channel i sets flag bit i on every clock in which the main count equals its match value while run enable is 1 and counter clear is 0.
- R11: In the capture configuration register, bits [1:0] belong to channel 0 and bits [3:2] to channel 1. Within each pair, the low bit arms rising edges and the high bit arms falling edges. On an armed edge the channel stores the main count in its capture register and sets its flag. This happens whether or not counting is enabled.
- R12: Word offsets on addr: 0 control, 1 mode, 2 prescale value, 3 flags, 4 main count (read-only), 5 prescale count (read-only), 6 capture configuration, 8 capture 0, 9 capture 1, 12 to 15 match 0 to 3. Writes take effect at the clock edge where wr_en is high. Reads are combinational from addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word offset for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| cap_in | input | 2 | Asynchronous capture inputs 0 and 1 |

## Verification
The assertions check these rules on every cycle:
- the counter clear forces both counts to zero;
- a disabled counter holds still;
- the prescale counter wraps and the main count steps together;
- in counter mode the count holds when there is no edge;
- a set flag survives a simultaneous clear, and a cleared flag drops;
- a capture register holds the count from the clock of its edge.

Only the bench scenarios show that the counts are correct after many clocks for several prescale values, and that the edge polarities and the input selection are right. They also show the exact synchronizer latency, and that a match flag is raised at the right count.

// File: rtl/ptc_pkg.sv
// Package: shared register offsets, channel counts and the count-source
// encoding for the prescaled timer/counter. Assumes a 4-bit word offset.
package ptc_pkg;
    localparam int ADDR_W   = 4;
    localparam int N_MATCH  = 4;
    localparam int N_CAP    = 2;
    localparam int N_FLAG   = N_MATCH + N_CAP;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_PSC    = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_FLAGS  = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_COUNT  = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_PCNT   = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_CAPCFG = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_CAP0   = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_CAP1   = 4'd9;

    typedef enum logic [1:0] {
        SRC_PRESCALE = 2'b00,
        SRC_RISE     = 2'b01,
        SRC_FALL     = 2'b10,
        SRC_BOTH     = 2'b11
    } cnt_src_e;
endpackage

// File: rtl/ptc_edge_sync.sv
// Module: ptc_edge_sync
// Brings one asynchronous input into the clock domain through a STAGES-deep
// flop chain, then flags rising and falling edges by comparing the
// synchronized level with its value one clock earlier.
// Assumes STAGES >= 2.
module ptc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the input through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ptc_count_core.sv
// Module: ptc_count_core
// Holds the prescale counter and the main count. In timer mode the prescale
// counter steps each clock and wraps while the main count steps. In counter
// mode the main count steps on edge_tick. hold_zero overrides everything.
// Assumes psc can be changed at any time: a prescale count above psc wraps
// on the next running clock.
module ptc_count_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         hold_zero,
    input  logic         timer_mode,
    input  logic         edge_tick,
    input  logic [W-1:0] psc,
    output logic [W-1:0] tc,
    output logic [W-1:0] pc
);
    logic wrap;
    assign wrap = (pc >= psc);

    // Advance the prescale counter and the main count per the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_zero) begin
            tc <= '0;
            pc <= '0;
        end else if (run) begin
            if (timer_mode) begin
                if (wrap) begin
                    pc <= '0;
                    tc <= tc + 1'b1;
                end else begin
                    pc <= pc + 1'b1;
                end
            end else if (edge_tick) begin
                tc <= tc + 1'b1;
            end
        end
    end

    assert_hold_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hold_zero |=> (tc == '0 && pc == '0));

    assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !hold_zero) |=> ($stable(tc) && $stable(pc)));

    assert_wrap_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !hold_zero && timer_mode && wrap)
        |=> (pc == '0 && tc == W'($past(tc) + 1'b1)));

    assert_no_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !hold_zero && !timer_mode && !edge_tick)
        |=> ($stable(tc) && $stable(pc)));
endmodule

// File: rtl/ptc_event_unit.sv
// Module: ptc_event_unit
// Compares the main count against NM match values and records the count on
// armed capture edges. Keeps the flag register: match flags in the low NM
// bits, capture flags above them. A write-one clear loses to a set event in
// the same clock.
module ptc_event_unit #(
    parameter int W  = 32,
    parameter int NM = 4,
    parameter int NC = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic [W-1:0]           tc,
    input  logic [NM-1:0][W-1:0]   match_val,
    input  logic [NC-1:0]          cap_rise,
    input  logic [NC-1:0]          cap_fall,
    input  logic [2*NC-1:0]        cap_cfg,
    input  logic [NM+NC-1:0]       clr_mask,
    output logic [NM+NC-1:0]       flags,
    output logic [NC-1:0][W-1:0]   cap_val
);
    localparam int NF = NM + NC;

    logic [NF-1:0] set_vec;

    for (genvar m = 0; m < NM; m++) begin : g_match
        assign set_vec[m] = run && (tc == match_val[m]);
    end

    for (genvar c = 0; c < NC; c++) begin : g_cap
        logic         trig;
        logic [W-1:0] cap_q;
        assign trig = (cap_cfg[2*c] & cap_rise[c]) | (cap_cfg[2*c+1] & cap_fall[c]);
        assign set_vec[NM+c] = trig;
        assign cap_val[c] = cap_q;

        // Store the main count when an armed edge arrives on this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)    cap_q <= '0;
            else if (trig) cap_q <= tc;
        end

        assert_capture_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
            trig |=> (cap_q == $past(tc)));
    end

    // Update the flags: clear by mask, then let new events override.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | set_vec;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((flags & $past(clr_mask & ~set_vec)) == '0));
endmodule

// File: rtl/ptc_top.sv
// Module: ptc_top
// Prescaled 32-bit timer/counter with a word-addressed register port. It
// holds the control, mode, prescale, capture configuration and match
// registers, picks the count source, and muxes read data.
// Assumes the capture inputs are asynchronous and the register port is
// synchronous to clk.
module ptc_top
    import ptc_pkg::*;
#(
    parameter int W       = 32,
    parameter int SYNC_FF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic [N_CAP-1:0]  cap_in
);
    localparam logic [1:0] CTRL_RST_VAL = 2'b10;

    logic [1:0]                 ctrl_q;
    logic [3:0]                 mode_q;
    logic [W-1:0]               psc_q;
    logic [2*N_CAP-1:0]         capcfg_q;
    logic [N_MATCH-1:0][W-1:0]  match_q;

    logic [N_CAP-1:0]           cap_rise, cap_fall;
    logic [W-1:0]               tc, pc;
    logic [N_FLAG-1:0]          flags, clr_mask;
    logic [N_CAP-1:0][W-1:0]    cap_val;
    logic                       edge_tick, timer_mode, run_en, hold_zero, sel;
    cnt_src_e                   src;

    // Register writes from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RST_VAL;
            mode_q   <= '0;
            psc_q    <= '0;
            capcfg_q <= '0;
            match_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                ADR_CTRL:   ctrl_q   <= wdata[1:0];
                ADR_MODE:   mode_q   <= wdata[3:0];
                ADR_PSC:    psc_q    <= wdata;
                ADR_CAPCFG: capcfg_q <= wdata[2*N_CAP-1:0];
                default: begin
                    if (addr[3:2] == 2'b11) match_q[addr[1:0]] <= wdata;
                end
            endcase
        end
    end

    assign clr_mask   = (wr_en && addr == ADR_FLAGS) ? wdata[N_FLAG-1:0] : '0;
    assign run_en     = ctrl_q[0];
    assign hold_zero  = ctrl_q[1];
    assign src        = cnt_src_e'(mode_q[1:0]);
    assign sel        = mode_q[2];
    assign timer_mode = (src == SRC_PRESCALE);

    for (genvar c = 0; c < N_CAP; c++) begin : g_sync
        ptc_edge_sync #(.STAGES(SYNC_FF)) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cap_in[c]),
            .rise (cap_rise[c]),
            .fall (cap_fall[c])
        );
    end

    // Choose the counted edge from the selected input and polarity.
    always_comb begin
        case (src)
            SRC_RISE: edge_tick = cap_rise[sel];
            SRC_FALL: edge_tick = cap_fall[sel];
            SRC_BOTH: edge_tick = cap_rise[sel] | cap_fall[sel];
            default:  edge_tick = 1'b0;
        endcase
    end

    ptc_count_core #(.W(W)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_en),
        .hold_zero (hold_zero),
        .timer_mode(timer_mode),
        .edge_tick (edge_tick),
        .psc       (psc_q),
        .tc        (tc),
        .pc        (pc)
    );

    ptc_event_unit #(.W(W), .NM(N_MATCH), .NC(N_CAP)) evt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en && !hold_zero),
        .tc       (tc),
        .match_val(match_q),
        .cap_rise (cap_rise),
        .cap_fall (cap_fall),
        .cap_cfg  (capcfg_q),
        .clr_mask (clr_mask),
        .flags    (flags),
        .cap_val  (cap_val)
    );

    // Read-data mux by word offset.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL:   rdata[1:0]         = ctrl_q;
            ADR_MODE:   rdata[3:0]         = mode_q;
            ADR_PSC:    rdata              = psc_q;
            ADR_FLAGS:  rdata[N_FLAG-1:0]  = flags;
            ADR_COUNT:  rdata              = tc;
            ADR_PCNT:   rdata              = pc;
            ADR_CAPCFG: rdata[2*N_CAP-1:0] = capcfg_q;
            ADR_CAP0:   rdata              = cap_val[0];
            ADR_CAP1:   rdata              = cap_val[1];
            default: begin
                if (addr[3:2] == 2'b11) rdata = match_q[addr[1:0]];
            end
        endcase
    end

    assert_ctrl_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctrl_q == CTRL_RST_VAL));

    assert_prescale_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_mode && !hold_zero) |=> $stable(pc));
endmodule

// File: tb/ptc_top_tb_top.sv
module ptc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [1:0]  cap_in;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [3:0] A_CTRL = 4'd0, A_MODE = 4'd1, A_PSC = 4'd2, A_FLAGS = 4'd3,
                           A_COUNT = 4'd4, A_PCNT = 4'd5, A_CAPCFG = 4'd6,
                           A_CAP0 = 4'd8, A_CAP1 = 4'd9, A_M0 = 4'd12;

    // Each row: prescale value, running clocks, expected count, expected prescale count (R3).
    localparam int NV = 6;
    localparam int VEC [NV][4] = '{
        '{0, 5, 5, 0},
        '{1, 5, 2, 1},
        '{2, 9, 3, 0},
        '{3, 7, 1, 3},
        '{4, 4, 0, 4},
        '{9, 30, 3, 0}
    };

    always #4ns clk = ~clk;

    ptc_top dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .cap_in(cap_in)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1ns;
        v = rdata;
    endtask

    task automatic pulse(input int ch);
        cap_in[ch] = 1'b1;
        repeat (4) @(negedge clk);
        cap_in[ch] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic restart(input logic [31:0] mode);
        wr(A_CTRL, 32'h2);
        wr(A_MODE, mode);
        wr(A_CTRL, 32'h1);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #1200us;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; cap_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R1, R7, R12
        peek(A_CTRL, v);  check("R1 ctrl after reset", v, 32'h2);
        peek(A_COUNT, v); check("R12 count after reset", v, 32'h0);
        peek(A_FLAGS, v); check("R7 flags after reset", v, 32'h0);

        // Timer-mode vector table (R3)
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, 32'h2);
            wr(A_PSC, VEC[i][0]);
            wr(A_MODE, 32'h0);
            wr(A_CTRL, 32'h1);
            repeat (VEC[i][1]) @(posedge clk);
            @(negedge clk);
            peek(A_COUNT, v); check("R3 main count", v, VEC[i][2]);
            peek(A_PCNT, v);  check("R3 prescale count", v, VEC[i][3]);
        end

        // Counter clear held with enable set (R1)
        wr(A_CTRL, 32'h3);
        repeat (5) @(negedge clk);
        peek(A_COUNT, v); check("R1 count held zero", v, 32'h0);
        peek(A_PCNT, v);  check("R1 prescale held zero", v, 32'h0);

        // Disable freezes counts (R2)
        wr(A_PSC, 32'h0);
        wr(A_CTRL, 32'h1);
        repeat (6) @(negedge clk);
        wr(A_CTRL, 32'h0);
        peek(A_COUNT, v);
        repeat (10) @(negedge clk);
        peek(A_COUNT, v2); check("R2 count frozen", v2, v);
        check("R2 count nonzero before freeze", 32'(v != 0), 32'h1);

        // Keep match channels out of the way
        wr(A_M0 + 4'd1, 32'd100);
        wr(A_M0 + 4'd2, 32'd200);
        wr(A_M0 + 4'd3, 32'd300);
        wr(A_M0, 32'd1000);

        // Edge polarities on input 0 (R4)
        restart(32'h1);
        repeat (3) pulse(0);
        peek(A_COUNT, v); check("R4 rising edges", v, 32'd3);
        peek(A_PCNT, v);  check("R4 prescale idle", v, 32'd0);
        restart(32'h2);
        repeat (3) pulse(0);
        peek(A_COUNT, v); check("R4 falling edges", v, 32'd3);
        restart(32'h3);
        repeat (2) pulse(0);
        peek(A_COUNT, v); check("R4 both edges", v, 32'd4);

        // Input selection (R5)
        restart(32'h5);
        repeat (2) pulse(0);
        peek(A_COUNT, v); check("R5 unselected input ignored", v, 32'd0);
        pulse(1);
        peek(A_COUNT, v); check("R5 input 1 counted", v, 32'd1);

        // Synchronizer latency (R6)
        restart(32'h1);
        cap_in[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        peek(A_COUNT, v); check("R6 not counted after two edges", v, 32'd0);
        @(posedge clk);
        @(negedge clk);
        peek(A_COUNT, v); check("R6 counted at third edge", v, 32'd1);
        cap_in[0] = 1'b0;
        repeat (4) @(negedge clk);

        // Match, set-wins, write-one-clear (R10, R9, R8)
        wr(A_M0, 32'd3);
        restart(32'h1);
        wr(A_FLAGS, 32'h3F);
        repeat (2) pulse(0);
        peek(A_FLAGS, v); check("R10 no match at count 2", v & 32'h1, 32'h0);
        pulse(0);
        peek(A_FLAGS, v); check("R10 match flag at count 3", v & 32'h1, 32'h1);
        wr(A_FLAGS, 32'h0);
        peek(A_FLAGS, v); check("R8 write zero keeps flag", v & 32'h1, 32'h1);
        wr(A_FLAGS, 32'h1);
        peek(A_FLAGS, v); check("R9 set beats clear", v & 32'h1, 32'h1);
        wr(A_M0, 32'd50);
        wr(A_FLAGS, 32'h1);
        peek(A_FLAGS, v); check("R8 write one clears", v & 32'h1, 32'h0);

        // Capture on falling edge of input 1 while stopped (R11, R7)
        wr(A_CAPCFG, 32'h8);
        restart(32'h0);
        repeat (7) @(negedge clk);
        wr(A_CTRL, 32'h0);
        wr(A_FLAGS, 32'h3F);
        peek(A_COUNT, v);
        pulse(1);
        peek(A_CAP1, v2); check("R11 capture 1 holds count", v2, v);
        peek(A_CAP0, v2); check("R11 capture 0 untouched", v2, 32'h0);
        peek(A_FLAGS, v2); check("R7 only capture 1 flag, upper zero", v2, 32'h20);

        summary();
        $finish;
    end
endmodule